// File: doc/BRIEF.md
# Beat-Frequency Jitter Counter Harvester

This block turns the relative drift of two free-running clocks of nearly equal frequency into a stream of random bits. A single flip-flop, clocked by the slower clock, samples the faster clock as data. Its output rises once for every beat, which is the point where the faster clock has gained one whole cycle on the slower one. Jitter on either clock moves each beat by a varying number of slow-clock cycles. That variation is the entropy source.

Everything after the beat flip-flop runs in the slow-clock domain. The beat level passes through a two-flop synchronizer, and a one-cycle pulse is taken from its rising edge. A saturating counter measures the slow-clock cycles between pulses. On each pulse the counter's present value is captured as the interval peak and the counter restarts from zero.

The three least significant bits of each peak go into a small shift register. They leave one per cycle, most significant first, each with a valid strobe. If a new peak arrives while bits are still pending, that peak is dropped and a sticky overrun flag is raised. A second flag records whether the last captured interval ran into the counter's ceiling.

Top module: `beat_harvester`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, rnd_valid, overrun and sat_flag are 0.
- R2: On every rising clk_slow edge the beat flip-flop stores the level of clk_fast. The stored level passes through two synchronizer flops and one edge flop. A beat pulse lasts exactly one cycle: the cycle in which the second synchronizer flop is 1 and the edge flop is 0.
- R3: The interval counter is CNT_W bits wide. It goes to 0 on the edge that ends a beat-pulse cycle. Otherwise it increments by 1 on every clk_slow edge and holds at 2^CNT_W-1 without wrapping.
- R4: In a beat-pulse cycle, the low 3 bits of the counter's present value are the peak bits handed to the serializer.
- R5: An accepted peak appears on rnd_bit over 3 consecutive cycles, starting the cycle after the beat pulse, in the order bit 2, bit 1, bit 0. rnd_valid is 1 in exactly those cycles.
- R6: A beat pulse that arrives while any bit of the previous peak is still pending, including its last one, is dropped. overrun then rises on the next cycle and stays 1 until reset.
- R7: On every beat pulse, whether accepted or dropped, sat_flag is updated on the next cycle. It becomes 1 when the captured count equals 2^CNT_W-1 and 0 otherwise, and it holds that value until the next pulse.
- R8: rnd_valid is 0 in every cycle with no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slower free-running clock; clocks all logic |
| clk_fast | input | 1 | Faster free-running clock; sampled as data only |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnd_bit | output | 1 | Serial random bit, meaningful when rnd_valid is 1 |
| rnd_valid | output | 1 | Strobe marking each output bit |
| overrun | output | 1 | Sticky flag: a peak was dropped |
| sat_flag | output | 1 | The last captured interval reached the counter ceiling |

## Verification
Any fault in the beat path, the synchronizer depth or the counter shows up within one beat interval, as a wrong 3-bit group on rnd_bit or as a group that appears one cycle early or late. The reference model compares every cycle, so a single-cycle shift in the pulse or a miscounted increment fails on the first group that follows it. A serializer that accepts a peak while it is still busy, or that clears the sticky flag, is caught in the closely spaced beat phase within a few cycles. A counter that wraps instead of saturating gives a wrong sat_flag and wrong bits as soon as an interval runs longer than the counter range.

// File: rtl/beat_harv_pkg.sv
`timescale 1ns/1ps
package beat_harv_pkg;

  // Next value of the interval counter: restart on a beat, else count up and stick at the top.
  function automatic int unsigned next_count(input int unsigned cur,
                                             input int unsigned top,
                                             input bit          restart);
    if (restart)     return 0;
    if (cur >= top)  return top;
    return cur + 1;
  endfunction

  // Number of bits still to send after one shift.
  function automatic int unsigned after_shift(input int unsigned left);
    return (left == 0) ? 0 : left - 1;
  endfunction

endpackage

// File: rtl/beat_sampler.sv
`timescale 1ns/1ps
module beat_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_slow,
  input  logic rst_n,
  input  logic clk_fast,
  output logic beat_pulse
);
  localparam int CHAIN_W = SYNC_STAGES + 1;   // synchronizer plus edge flop

  logic               beat_raw;
  logic [CHAIN_W-1:0] chain_q;

  // Beat detector: slower clock samples the faster one.
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) beat_raw <= 1'b0;
    else        beat_raw <= clk_fast;
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], beat_raw};
  end

  assign beat_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R2: a beat pulse never lasts two cycles
  assert_pulse_single_R2: assert property (@(posedge clk_slow) disable iff (!rst_n)
    beat_pulse |=> !beat_pulse);
endmodule

// File: rtl/interval_counter.sv
`timescale 1ns/1ps
module interval_counter #(
  parameter int CNT_W    = 8,
  parameter int OUT_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat_pulse,
  output logic [OUT_BITS-1:0] peak_bits,
  output logic                sat_flag
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top    = (cnt_q == CNT_TOP);
  assign peak_bits = cnt_q[OUT_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sat_flag <= 1'b0;
    end else begin
      cnt_q <= CNT_W'(beat_harv_pkg::next_count(32'(cnt_q), 32'(CNT_TOP), beat_pulse));
      if (beat_pulse) sat_flag <= at_top;
    end
  end

  // R3: cleared after every beat
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_pulse |=> (cnt_q == '0));
  // R3: holds at the ceiling
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !beat_pulse) |=> at_top);
  // R3: steps by one below the ceiling
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_top && !beat_pulse) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7: flag only changes right after a pulse
  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_pulse |=> $stable(sat_flag));
endmodule

// File: rtl/bit_serializer.sv
`timescale 1ns/1ps
module bit_serializer #(
  parameter int OUT_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_req,
  input  logic [OUT_BITS-1:0] load_bits,
  output logic                rnd_bit,
  output logic                rnd_valid,
  output logic                overrun
);
  localparam int LEFT_W = $clog2(OUT_BITS + 1);

  logic [OUT_BITS-1:0] shreg_q;
  logic [LEFT_W-1:0]   left_q;
  logic                busy;
  logic                accept;
  logic                drop;

  assign busy      = (left_q != '0);
  assign accept    = load_req && !busy;
  assign drop      = load_req && busy;
  assign rnd_valid = busy;
  assign rnd_bit   = shreg_q[OUT_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) begin
        shreg_q <= load_bits;
        left_q  <= LEFT_W'(OUT_BITS);
      end else begin
        shreg_q <= {shreg_q[OUT_BITS-2:0], 1'b0};
        left_q  <= LEFT_W'(beat_harv_pkg::after_shift(32'(left_q)));
      end
      if (drop) overrun <= 1'b1;
    end
  end

  // R5: an accepted peak starts on the next cycle
  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rnd_valid);
  // R5: a group is not cut short
  assert_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left_q > 1) |=> rnd_valid);
  // R6: dropping a peak raises overrun
  assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  // R6: overrun is sticky
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/beat_harvester.sv
`timescale 1ns/1ps
module beat_harvester #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic rst_n,
  output logic rnd_bit,
  output logic rnd_valid,
  output logic overrun,
  output logic sat_flag
);
  localparam int OUT_BITS = 3;

  logic                beat_pulse;
  logic [OUT_BITS-1:0] peak_bits;

  beat_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_slow  (clk_slow),
    .rst_n     (rst_n),
    .clk_fast  (clk_fast),
    .beat_pulse(beat_pulse)
  );

  interval_counter #(.CNT_W(CNT_W), .OUT_BITS(OUT_BITS)) u_counter (
    .clk       (clk_slow),
    .rst_n     (rst_n),
    .beat_pulse(beat_pulse),
    .peak_bits (peak_bits),
    .sat_flag  (sat_flag)
  );

  bit_serializer #(.OUT_BITS(OUT_BITS)) u_serial (
    .clk      (clk_slow),
    .rst_n    (rst_n),
    .load_req (beat_pulse),
    .load_bits(peak_bits),
    .rnd_bit  (rnd_bit),
    .rnd_valid(rnd_valid),
    .overrun  (overrun)
  );

  // R1: nothing is presented on the cycle after reset release
  assert_reset_quiet_R1: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $rose(rst_n) |-> (!rnd_valid && !overrun && !sat_flag));
endmodule

// File: tb/test_beat_harvester.sv
`timescale 1ns/1ps
module test_beat_harvester;
  localparam int CNT_W = 6;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk_slow = 1'b0;
  logic clk_fast = 1'b0;
  logic rst_n    = 1'b0;
  logic rnd_bit, rnd_valid, overrun, sat_flag;
  real  half_fast = 4.85;

  int tests = 0;
  int fails = 0;

  beat_harvester #(.CNT_W(CNT_W)) i_beat_harvester (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .rnd_bit(rnd_bit), .rnd_valid(rnd_valid), .overrun(overrun), .sat_flag(sat_flag)
  );

  // 100 MHz slow clock; edges on multiples of 50 ps
  always #5 clk_slow = ~clk_slow;
  // Fast clock edges stay 34 ps off the 50 ps grid, so they never meet a slow edge
  initial begin
    #1.234;
    forever #(half_fast) clk_fast = ~clk_fast;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_raw, m_s1, m_s2, m_s3, m_cnt;
  bit m_ovr, m_sat;
  bit q[$];
  int sat_events = 0, drop_events = 0, groups = 0;

  always @(posedge clk_slow) begin
    if (!rst_n) begin
      m_raw = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0;
      m_ovr = 0; m_sat = 0; q.delete();
    end else begin
      bit pulse;
      int had;
      pulse = (m_s2 == 1) && (m_s3 == 0);
      had   = q.size();
      if (had > 0) void'(q.pop_front());
      if (pulse) begin
        if (had == 0) begin
          for (int b = 2; b >= 0; b--) q.push_back(((m_cnt >> b) & 1) != 0);
          groups++;
        end else begin
          m_ovr = 1;
          drop_events++;
        end
        m_sat = (m_cnt == MAXC);
        if (m_sat) sat_events++;
      end
      m_cnt = pulse ? 0 : ((m_cnt < MAXC) ? m_cnt + 1 : MAXC);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = m_raw; m_raw = int'(clk_fast);
    end
  end

  // Compare every cycle, half a period after the edge
  always @(negedge clk_slow) begin
    if (rst_n) begin
      check(rnd_valid == (q.size() > 0), "R5/R8 rnd_valid", int'(rnd_valid), int'(q.size() > 0));
      if (q.size() > 0 && rnd_valid)
        check(rnd_bit == q[0], "R4/R5 rnd_bit", int'(rnd_bit), int'(q[0]));
      check(overrun == m_ovr, "R6 overrun", int'(overrun), int'(m_ovr));
      check(sat_flag == m_sat, "R7 sat_flag", int'(sat_flag), int'(m_sat));
    end
  end

  task automatic reset_check(input string tag);
    check(rnd_valid == 1'b0, {tag, " R1 rnd_valid"}, int'(rnd_valid), 0);
    check(overrun == 1'b0, {tag, " R1 overrun"}, int'(overrun), 0);
    check(sat_flag == 1'b0, {tag, " R1 sat_flag"}, int'(sat_flag), 0);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_slow);
    reset_check("in reset");
    rst_n = 1'b1;
    @(negedge clk_slow);
    reset_check("after release");
    // R2/R3/R4: ~33-cycle beats, below the ceiling
    repeat (3000) @(posedge clk_slow);
    check(groups > 20, "R2 beats produce groups", groups, 21);
    check(sat_events == 0, "R7 no saturation at short beats", sat_events, 0);
    // R6: beats every few cycles collide with pending bits
    half_fast = 3.0;
    repeat (300) @(posedge clk_slow);
    @(negedge clk_slow);
    check(drop_events > 0, "R6 collisions stimulated", drop_events, 1);
    check(overrun == 1'b1, "R6 overrun sticky set", int'(overrun), 1);
    // R3/R7: ~100-cycle beats overflow a 6-bit range
    half_fast = 4.95;
    repeat (1500) @(posedge clk_slow);
    check(sat_events > 0, "R3 saturation stimulated", sat_events, 1);
    check(overrun == 1'b1, "R6 overrun still set", int'(overrun), 1);
    // Mid-run reset, then new intervals
    @(negedge clk_slow);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_slow);
    reset_check("mid reset");
    half_fast = 4.9;
    rst_n = 1'b1;
    @(negedge clk_slow);
    reset_check("after mid release");
    repeat (1500) @(posedge clk_slow);
    half_fast = 4.8;
    repeat (1000) @(posedge clk_slow);
    @(negedge clk_slow);
    check(overrun == 1'b0, "R6 overrun clear after reset, no collisions", int'(overrun), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule